// File: doc/BRIEF.md
# External Pin Interrupt Sense Unit

This unit watches eight asynchronous external interrupt lines. Each line gets its own 2-bit sense code, which picks one of four conditions: active-low level, falling edge, rising edge, or any edge. For each line the unit drives one active-high level request toward a parent interrupt controller. The parent therefore sees the same polarity and kind of signal whatever sense a line uses.

Every line passes through a two-flop synchroniser. A stage that holds the previous synchronised sample follows it, and edges are found by comparing the two.

- In the edge modes, an event sets a sticky status bit. Software clears that bit by writing 0 to it.
- In level-low mode, the status bit simply mirrors the inverted synchronised line and cannot be cleared.

Software reaches the unit through a small 32-bit register bus. Writes take effect at the clock edge, and reads return data combinationally from the current address.

Top module: `pin_sense_unit`

## Requirements
- R1: After reset the status register (offset 0x10) and the sense register (offset 0x14) both read 0. With all lines held high, every request output is 0. Unmapped offsets read 0.
- R2: Each line is seen through two synchronising flops. In level-low mode, a line driven low before clock edge k makes its request output rise after edge k+1, and not after edge k alone.
- R3: With sense code 0 (level low), the line's status bit and request follow the inverted synchronised line with no latching. Writing 0 to that status bit has no effect.
- R4: With sense code 1, a high-to-low transition sets the status bit, which stays set after the line returns high. A low-to-high transition does not set it.
- R5: With sense code 2, a low-to-high transition sets the status bit. A high-to-low transition does not set it.
- R6: With sense code 3, either transition sets the status bit.
- R7: In an edge mode (codes 1 to 3), writing 0 to status bit n clears it at the write edge.
- R8: Writing 1 to a status bit has no effect.
- R9: If an edge event and a clear-write for the same bit land on the same clock edge, the bit ends up 1.
- R10: Line n's sense code sits at bits [2n+1:2n] of offset 0x14. The register reads back what was written in bits [15:0]; bits [31:16] read 0.
- R11: Request output n is an active-high level that equals status bit n in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_in | input | 8 | Asynchronous external interrupt lines |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_out | output | 8 | Active-high request per line toward the parent controller |

## Verification
Each sense code is driven with both a falling and a rising transition on its own line. The checks confirm that only the selected direction latches and that a latched bit survives the line returning to idle. That separates codes 1, 2 and 3 from one another and from level mode, where releasing the line drops the request. A line pulled low in level mode is sampled one and two edges later to pin down the synchroniser depth. Clear-writes are issued in level mode, in edge mode, with 1-bits, and on the very edge where a new transition is detected, which separates gated clearing, write-one immunity and set priority.

// File: rtl/psu_pkg.sv
package psu_pkg;

  typedef enum logic [1:0] {
    SENSE_LVL_LOW = 2'd0,
    SENSE_FALL    = 2'd1,
    SENSE_RISE    = 2'd2,
    SENSE_ANY     = 2'd3
  } sense_e;

  localparam logic [7:0] OFF_STATUS = 8'h10;
  localparam logic [7:0] OFF_SENSE  = 8'h14;

  // True for the three sense codes that latch events.
  function automatic logic is_edge_mode(input logic [1:0] code);
    return code != SENSE_LVL_LOW;
  endfunction

  // Edge event for one line given its code, current and previous sample.
  function automatic logic edge_hit(input logic [1:0] code,
                                    input logic cur, input logic prev);
    logic rise, fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    case (sense_e'(code))
      SENSE_FALL: return fall;
      SENSE_RISE: return rise;
      SENSE_ANY:  return rise | fall;
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/psu_sync.sv
module psu_sync #(
  parameter int N_PINS = 8,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] raw,
  output logic [N_PINS-1:0] cur,
  output logic [N_PINS-1:0] prev
);
  localparam int DEPTH = STAGES + 1;

  logic [N_PINS-1:0] stg [DEPTH];

  // Stages preset to the idle-high level of active-low lines.
  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '1;
        else        stg[0] <= raw;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '1;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign cur  = stg[STAGES-1];
  assign prev = stg[STAGES];
endmodule

// File: rtl/psu_chan.sv
module psu_chan
  import psu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       cur,
  input  logic       prev,
  input  logic       clr_req,
  output logic       ev,
  output logic       req
);
  logic edge_mode;
  logic clr_ok;
  logic stat_q;

  assign edge_mode = is_edge_mode(mode);
  assign ev        = edge_hit(mode, cur, prev);
  assign clr_ok    = clr_req & edge_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          stat_q <= 1'b0;
    else if (!edge_mode) stat_q <= 1'b0;
    else if (ev)         stat_q <= 1'b1;
    else if (clr_ok)     stat_q <= 1'b0;
  end

  assign req = edge_mode ? stat_q : ~cur;
endmodule

// File: rtl/psu_regs.sv
module psu_regs
  import psu_pkg::*;
#(
  parameter int N_PINS = 8,
  parameter int AW     = 8,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [N_PINS-1:0] status,
  output logic [2*N_PINS-1:0] sense_q,
  output logic [N_PINS-1:0] clr_req
);
  localparam int SW = 2 * N_PINS;

  logic hit_status, hit_sense;
  logic unused_hi;

  assign hit_status = bus_addr == AW'(OFF_STATUS);
  assign hit_sense  = bus_addr == AW'(OFF_SENSE);
  assign unused_hi  = ^bus_wdata[DW-1:SW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  sense_q <= '0;
    else if (bus_wr && hit_sense) sense_q <= bus_wdata[SW-1:0];
  end

  // A 0 in the write data asks for a clear; the channel gates it by mode.
  assign clr_req = (bus_wr && hit_status) ? ~bus_wdata[N_PINS-1:0] : '0;

  always_comb begin
    bus_rdata = '0;
    if (hit_status) bus_rdata[N_PINS-1:0] = status;
    if (hit_sense)  bus_rdata[SW-1:0]     = sense_q;
  end
endmodule

// File: rtl/pin_sense_unit.sv
module pin_sense_unit #(
  parameter int N_PINS      = 8,
  parameter int AW          = 8,
  parameter int DW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pins_in,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [N_PINS-1:0] irq_out
);
  localparam int SW = 2 * N_PINS;

  logic [N_PINS-1:0] sync_cur, sync_prev;
  logic [N_PINS-1:0] edge_ev;
  logic [N_PINS-1:0] clr_req;
  logic [SW-1:0]     sense_flat;

  psu_sync #(.N_PINS(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(pins_in),
    .cur(sync_cur), .prev(sync_prev)
  );

  psu_regs #(.N_PINS(N_PINS), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .status(irq_out),
    .sense_q(sense_flat), .clr_req(clr_req)
  );

  for (genvar i = 0; i < N_PINS; i++) begin : g_chan
    psu_chan u_chan (
      .clk(clk), .rst_n(rst_n), .mode(sense_flat[2*i +: 2]),
      .cur(sync_cur[i]), .prev(sync_prev[i]), .clr_req(clr_req[i]),
      .ev(edge_ev[i]), .req(irq_out[i])
    );
  end
endmodule

// File: rtl/psu_checker.sv
module psu_checker #(
  parameter int N_PINS = 8,
  parameter int AW     = 8,
  parameter int DW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_PINS-1:0] pins_in,
  input logic              bus_wr,
  input logic [AW-1:0]     bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic [N_PINS-1:0] irq_out,
  input logic [N_PINS-1:0] sync_cur,
  input logic [N_PINS-1:0] edge_ev,
  input logic [2*N_PINS-1:0] sense_flat
);
  logic [1:0] since_rst;
  logic       sense_wr, status_wr;

  assign sense_wr  = bus_wr && bus_addr == AW'(8'h14);
  assign status_wr = bus_wr && bus_addr == AW'(8'h10);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  a_r2_sync_lag: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> sync_cur == $past(pins_in, 2));

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    a_r3_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_flat[2*i +: 2] == 2'd0) |-> irq_out[i] == ~sync_cur[i]);

    a_r7_clear_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_flat[2*i +: 2] != 2'd0 && status_wr && !bus_wdata[i]
       && !edge_ev[i] && !sense_wr) |=> !irq_out[i]);

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_flat[2*i +: 2] != 2'd0 && !edge_ev[i] && !sense_wr
       && !(status_wr && !bus_wdata[i])) |=> $stable(irq_out[i]));

    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_ev[i] && !sense_wr) |=> irq_out[i]);
  end
endmodule

bind pin_sense_unit psu_checker #(.N_PINS(N_PINS), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pins_in(pins_in), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_out(irq_out),
  .sync_cur(sync_cur), .edge_ev(edge_ev), .sense_flat(sense_flat)
);

// File: tb/pin_sense_unit_tb.sv
module pin_sense_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pins_in = 8'hFF;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  irq_out;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  localparam logic [7:0] A_STAT  = 8'h10;
  localparam logic [7:0] A_SENSE = 8'h14;

  always #5 clk = ~clk;

  pin_sense_unit u_dut (
    .clk(clk), .rst_n(rst_n), .pins_in(pins_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_pin(input int p, input logic v);
    @(negedge clk);
    pins_in[p] = v;
  endtask

  task automatic chk_irq(input int p, input logic exp, input string req);
    check(irq_out[p] === exp, req, {31'd0, irq_out[p]}, {31'd0, exp});
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(A_STAT, d);  check(d === 32'd0, "R1 status", d, 0);
    rd(A_SENSE, d); check(d === 32'd0, "R1 sense", d, 0);
    rd(8'h18, d);   check(d === 32'd0, "R1 unmapped", d, 0);
    check(irq_out === 8'h00, "R1 irq", {24'd0, irq_out}, 0);
  endtask

  task automatic t_level;
    logic [31:0] d;
    set_pin(0, 1'b0);
    @(posedge clk); #1 chk_irq(0, 1'b0, "R2 one edge");
    @(posedge clk); #1 chk_irq(0, 1'b1, "R2 two edges");
    rd(A_STAT, d); check(d[0] === 1'b1, "R3 status low", d, 1);
    wr(A_STAT, 32'h0);
    wait_cyc(1);
    rd(A_STAT, d); check(d[0] === 1'b1, "R3 clear ignored", d, 1);
    set_pin(0, 1'b1);
    wait_cyc(3);
    chk_irq(0, 1'b0, "R3 no latch");
  endtask

  task automatic t_fall;
    logic [31:0] d;
    set_pin(1, 1'b0);
    wait_cyc(3);
    wr(A_SENSE, 32'h0000_0004);
    wait_cyc(2);
    chk_irq(1, 1'b0, "R4 mode entry empty");
    set_pin(1, 1'b1); wait_cyc(4);
    chk_irq(1, 1'b0, "R4 rise ignored");
    set_pin(1, 1'b0); wait_cyc(4);
    chk_irq(1, 1'b1, "R4 fall latched");
    set_pin(1, 1'b1); wait_cyc(4);
    chk_irq(1, 1'b1, "R4 sticky");
    wr(A_STAT, 32'hFF);
    chk_irq(1, 1'b1, "R8 write one");
    rd(A_STAT, d); check(d[7:0] === {6'd0, 1'b1, 1'b0}, "R11 out equals status", d, 2);
    wr(A_STAT, 32'hFD);
    chk_irq(1, 1'b0, "R7 clear");
  endtask

  task automatic t_rise;
    wr(A_SENSE, 32'h0000_0020);
    set_pin(2, 1'b0); wait_cyc(4);
    chk_irq(2, 1'b0, "R5 fall ignored");
    set_pin(2, 1'b1); wait_cyc(4);
    chk_irq(2, 1'b1, "R5 rise latched");
    wr(A_STAT, 32'h0);
    chk_irq(2, 1'b0, "R7 clear rise");
  endtask

  task automatic t_any;
    wr(A_SENSE, 32'h0000_00C0);
    set_pin(3, 1'b0); wait_cyc(4);
    chk_irq(3, 1'b1, "R6 fall");
    wr(A_STAT, 32'h0);
    chk_irq(3, 1'b0, "R7 clear any");
    set_pin(3, 1'b1); wait_cyc(4);
    chk_irq(3, 1'b1, "R6 rise");
    wr(A_STAT, 32'h0);
  endtask

  task automatic t_set_wins;
    wr(A_SENSE, 32'h0000_0300);
    set_pin(4, 1'b0); wait_cyc(4);
    wr(A_STAT, 32'h0);
    chk_irq(4, 1'b0, "R9 pre-clear");
    set_pin(4, 1'b1);
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = 32'h0;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
    chk_irq(4, 1'b1, "R9 set wins");
    wr(A_STAT, 32'h0);
  endtask

  task automatic t_sense_reg;
    logic [31:0] d;
    wr(A_SENSE, 32'hFFFF_1B6C);
    rd(A_SENSE, d);
    check(d === 32'h0000_1B6C, "R10 readback", d, 32'h1B6C);
    wr(A_SENSE, 32'h0);
    rd(A_SENSE, d);
    check(d === 32'h0, "R10 restore", d, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_level();
    t_fall();
    t_rise();
    t_any();
    t_set_wins();
    t_sense_reg();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      n_checks++; n_errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule